// File: doc/BRIEF.md
# Banked Interrupt Priority Register Bank

This block stores an 8-bit priority for every interrupt of a controller. Four priorities share each 32-bit word, and the words sit in a window of the block's register space that starts at byte offset 0x400. Software reaches the words through a simple register bus. Each request carries a word-aligned address, four byte strobes, write data and the number of the requesting processor. Every request is answered on the following cycle. The bus has no ready signal, so the block never applies back-pressure and a request may be presented on every cycle. A smaller priority value marks a more urgent interrupt.

The first eight words hold interrupt IDs 0 to 31. Each connected processor has its own copy of these words, and the requester number on the access picks the copy. The remaining words are shared by all processors. Some parts of the window have no storage behind them: priority bits below the implemented precision, interrupt IDs at or above the implemented count, and words beyond `8*(LINES+1)`. These parts read as zero and ignore writes.

A query port serves a downstream arbiter. It takes an interrupt ID and a processor number and returns the stored priority one cycle later. That value is always a whole byte, either from before an update or from after it.

Top module: `prio_bank_regs`

## Requirements
- R1: After reset every priority field is zero, `rsp_valid` and `q_rvalid` are low, and `q_prio` is zero.
- R2: Word n is at byte address 0x400 + 4*n. Interrupt ID m lives in word m/4, in bits [8*(m%4)+7 : 8*(m%4)]. ID m is held in byte lane m%4 of that word.
- R3: Each strobe bit `req_strb[b]` on its own enables the write of byte lane b. Lanes whose strobe is low keep their values.
- R4: Every request cycle gives exactly one cycle with `rsp_valid` high, one cycle later. For a read, `rsp_rdata` carries the word. For a write, `rsp_rdata` is zero.
- R5: The following addresses read as zero and ignore writes: addresses outside 0x400–0x7FB, word 255, and any word index at or above `8*(LINES+1)`.
- R6: Only the upper `PRIO_BITS` bits of each field are stored. The lower `8-PRIO_BITS` bits read as zero and ignore writes. With `PRIO_BITS` = 5 the field mask is 0xF8.
- R7: A field whose interrupt ID is at or above `NUM_IRQ` reads as zero and ignores writes, on both the bus and the query port.
- R8: Words 0–7 are held separately for each requester numbered below `NUM_PE`. Words from 8 upward are one copy shared by all requesters.
- R9: An access to words 0–7 from a requester numbered at or above `NUM_PE` reads as zero and ignores writes. This covers every requester numbered 8 or higher. A query for an ID below 32 from such a requester returns zero.
- R10: `q_prio` is registered one cycle after `q_valid` and shows the stored field unchanged. A query in the same cycle as a write to that field returns the whole old byte. A query in the following cycle returns the whole new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address, word aligned |
| req_strb | input | 4 | Byte-lane write enables |
| req_wdata | input | 32 | Write data |
| req_cpu | input | 4 | Requesting processor number |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 32 | Read data (zero for writes) |
| q_valid | input | 1 | Priority query present |
| q_id | input | 10 | Queried interrupt ID |
| q_cpu | input | 4 | Processor the query is for |
| q_rvalid | output | 1 | Query result present |
| q_prio | output | 8 | Priority of the queried interrupt |

## Verification
The bench builds the block with `LINES` = 1, `NUM_IRQ` = 58, `PRIO_BITS` = 5 and `NUM_PE` = 4. This gives sixteen implemented words. Word 14 contains both live and dead IDs, word 15 is implemented but holds only dead IDs, and word 16 is the first unimplemented word. The 5-bit precision makes the masked low bits visible in every read-back value. Four banked processors let requester 5 probe the gap between the connected count and 8, and requester 9 probes the range beyond 8.

// File: rtl/prio_pkg.sv
package prio_pkg;
  typedef logic [7:0] prio_t;

  // Mask that keeps the upper 'bits' bits of a priority byte.
  function automatic prio_t prio_keep_mask(input int bits);
    prio_t m;
    for (int i = 0; i < 8; i++) m[i] = (i >= 8 - bits);
    return m;
  endfunction
endpackage

// File: rtl/prio_word_dec.sv
module prio_word_dec #(
  parameter int NWORDS  = 16,
  parameter int NUM_IRQ = 64,
  parameter int NUM_PE  = 4
) (
  input  logic [11:0] addr,
  input  logic [3:0]  cpu,
  output logic [7:0]  word,
  output logic        hit,
  output logic [3:0]  lane_ok
);
  logic in_window;
  logic bank_ok;

  always_comb begin
    word      = addr[9:2];
    in_window = (addr[11:10] == 2'b01) && (word != 8'hFF) && (int'(word) < NWORDS);
    bank_ok   = (word >= 8'd8) || (int'(cpu) < NUM_PE);
    hit       = in_window && bank_ok;
    for (int b = 0; b < 4; b++) begin
      lane_ok[b] = hit && (int'({word, 2'(b)}) < NUM_IRQ);
    end
  end
endmodule

// File: rtl/prio_id_dec.sv
module prio_id_dec #(
  parameter int NWORDS  = 16,
  parameter int NUM_IRQ = 64,
  parameter int NUM_PE  = 4
) (
  input  logic [9:0] id,
  input  logic [3:0] cpu,
  output logic [7:0] word,
  output logic [1:0] lane,
  output logic       ok
);
  always_comb begin
    word = id[9:2];
    lane = id[1:0];
    ok   = (int'(id) < NUM_IRQ) && (int'(word) < NWORDS) &&
           ((word >= 8'd8) || (int'(cpu) < NUM_PE));
  end
endmodule

// File: rtl/prio_store.sv
module prio_store
  import prio_pkg::*;
#(
  parameter int    NUM_PE = 4,
  parameter int    NWORDS = 16,
  parameter prio_t MASK   = 8'hF8,
  localparam int PE_W    = (NUM_PE > 1) ? $clog2(NUM_PE) : 1,
  localparam int NSHR    = (NWORDS > 8) ? NWORDS - 8 : 1,
  localparam int SH_W    = (NSHR > 1) ? $clog2(NSHR) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [PE_W-1:0] wr_pe,
  input  logic [7:0]      wr_word,
  input  logic [3:0]      wr_be,
  input  logic [31:0]     wr_data,
  input  logic [PE_W-1:0] a_pe,
  input  logic [7:0]      a_word,
  output logic [31:0]     a_data,
  input  logic [PE_W-1:0] b_pe,
  input  logic [7:0]      b_word,
  output logic [31:0]     b_data
);
  logic [31:0] bank_q [NUM_PE][8];
  logic [31:0] shr_q  [NSHR];
  logic [31:0] wmask;

  assign wmask = {4{MASK}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NUM_PE; p++)
        for (int w = 0; w < 8; w++) bank_q[p][w] <= '0;
      for (int s = 0; s < NSHR; s++) shr_q[s] <= '0;
    end else if (wr_en) begin
      for (int b = 0; b < 4; b++) begin
        if (wr_be[b]) begin
          if (wr_word < 8'd8)
            bank_q[wr_pe][wr_word[2:0]][8*b +: 8] <= wr_data[8*b +: 8] & wmask[8*b +: 8];
          else
            shr_q[SH_W'(wr_word - 8'd8)][8*b +: 8] <= wr_data[8*b +: 8] & wmask[8*b +: 8];
        end
      end
    end
  end

  always_comb begin
    a_data = (a_word < 8'd8) ? bank_q[a_pe][a_word[2:0]] : shr_q[SH_W'(a_word - 8'd8)];
    b_data = (b_word < 8'd8) ? bank_q[b_pe][b_word[2:0]] : shr_q[SH_W'(b_word - 8'd8)];
  end
endmodule

// File: rtl/prio_bank_regs.sv
module prio_bank_regs
  import prio_pkg::*;
#(
  parameter int LINES     = 1,
  parameter int NUM_IRQ   = 32 * (LINES + 1),
  parameter int PRIO_BITS = 5,
  parameter int NUM_PE    = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [11:0] req_addr,
  input  logic [3:0]  req_strb,
  input  logic [31:0] req_wdata,
  input  logic [3:0]  req_cpu,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  input  logic        q_valid,
  input  logic [9:0]  q_id,
  input  logic [3:0]  q_cpu,
  output logic        q_rvalid,
  output logic [7:0]  q_prio
);
  localparam int    NWORDS = 8 * (LINES + 1);
  localparam int    PE_W   = (NUM_PE > 1) ? $clog2(NUM_PE) : 1;
  localparam prio_t MASK   = prio_keep_mask(PRIO_BITS);

  logic [7:0]  bus_word;
  logic        bus_hit;
  logic [3:0]  bus_lane_ok;
  logic [7:0]  q_word;
  logic [1:0]  q_lane;
  logic        q_ok;
  logic [31:0] a_data;
  logic [31:0] b_data;
  logic [31:0] rd_word;
  logic        wr_en;

  prio_word_dec #(.NWORDS(NWORDS), .NUM_IRQ(NUM_IRQ), .NUM_PE(NUM_PE)) bus_dec_i (
    .addr(req_addr), .cpu(req_cpu), .word(bus_word), .hit(bus_hit), .lane_ok(bus_lane_ok)
  );

  prio_id_dec #(.NWORDS(NWORDS), .NUM_IRQ(NUM_IRQ), .NUM_PE(NUM_PE)) q_dec_i (
    .id(q_id), .cpu(q_cpu), .word(q_word), .lane(q_lane), .ok(q_ok)
  );

  assign wr_en = req_valid && req_write && bus_hit;

  prio_store #(.NUM_PE(NUM_PE), .NWORDS(NWORDS), .MASK(MASK)) store_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_pe(PE_W'(req_cpu)), .wr_word(bus_word),
    .wr_be(req_strb & bus_lane_ok), .wr_data(req_wdata),
    .a_pe(PE_W'(req_cpu)), .a_word(bus_word), .a_data(a_data),
    .b_pe(PE_W'(q_cpu)), .b_word(q_word), .b_data(b_data)
  );

  // Dead lanes are forced to zero on the way out.
  always_comb begin
    for (int b = 0; b < 4; b++)
      rd_word[8*b +: 8] = bus_lane_ok[b] ? a_data[8*b +: 8] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      q_rvalid  <= 1'b0;
      q_prio    <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= (req_valid && !req_write) ? rd_word : 32'h0;
      q_rvalid  <= q_valid;
      if (q_valid) q_prio <= q_ok ? b_data[{q_lane, 3'b000} +: 8] : 8'h00;
    end
  end
endmodule

// File: rtl/prio_bank_regs_chk.sv
module prio_bank_regs_chk #(
  parameter int LINES     = 1,
  parameter int NUM_IRQ   = 64,
  parameter int PRIO_BITS = 5,
  parameter int NUM_PE    = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_write,
  input logic [11:0] req_addr,
  input logic [3:0]  req_cpu,
  input logic        rsp_valid,
  input logic [31:0] rsp_rdata,
  input logic        q_valid,
  input logic [9:0]  q_id,
  input logic [3:0]  q_cpu,
  input logic        q_rvalid,
  input logic [7:0]  q_prio
);
  localparam int         NWORDS = 8 * (LINES + 1);
  localparam logic [7:0] LOWBITS = 8'hFF >> PRIO_BITS;

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R4
  AST_RSP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid)); // R4
  AST_WRITE_RSP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> (rsp_rdata == 32'h0)); // R4
  AST_RAZ_FAR_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && (req_addr[11:10] != 2'b01 || int'(req_addr[9:2]) >= NWORDS))
      |=> (rsp_rdata == 32'h0)); // R5
  AST_LOW_BITS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((rsp_rdata & {4{LOWBITS}}) == 32'h0)); // R6
  AST_QUERY_LOW_BITS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    q_rvalid |-> ((q_prio & LOWBITS) == 8'h0)); // R6
  AST_QUERY_DEAD_ID: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && int'(q_id) >= NUM_IRQ) |=> (q_prio == 8'h0)); // R7
  AST_FOREIGN_CPU_BANKED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr[11:10] == 2'b01 && req_addr[9:5] == 5'd0 &&
     int'(req_cpu) >= NUM_PE) |=> (rsp_rdata == 32'h0)); // R9
  AST_QUERY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && $past(q_valid) && q_id == $past(q_id) && q_cpu == $past(q_cpu) &&
     !$past(req_valid && req_write)) |=> $stable(q_prio)); // R10
endmodule

bind prio_bank_regs prio_bank_regs_chk #(
  .LINES(LINES), .NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS), .NUM_PE(NUM_PE)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_cpu(req_cpu), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
  .q_valid(q_valid), .q_id(q_id), .q_cpu(q_cpu), .q_rvalid(q_rvalid), .q_prio(q_prio)
);

// File: tb/prio_bank_regs_tb_top.sv
`timescale 1ns/1ps
module prio_bank_regs_tb_top;
  localparam int LINES = 1;
  localparam int NIRQ  = 58;
  localparam int PBITS = 5;
  localparam int NPE   = 4;
  localparam int NW    = 8 * (LINES + 1);
  localparam logic [7:0] MASK = 8'hF8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [3:0]  req_strb = '0, req_cpu = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        q_valid = 1'b0;
  logic [9:0]  q_id = '0;
  logic [3:0]  q_cpu = '0;
  logic        q_rvalid;
  logic [7:0]  q_prio;

  always #2 clk = ~clk;

  prio_bank_regs #(.LINES(LINES), .NUM_IRQ(NIRQ), .PRIO_BITS(PBITS), .NUM_PE(NPE)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_strb(req_strb), .req_wdata(req_wdata), .req_cpu(req_cpu),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .q_valid(q_valid), .q_id(q_id),
    .q_cpu(q_cpu), .q_rvalid(q_rvalid), .q_prio(q_prio)
  );

  typedef struct { logic [31:0] v; string tag; } exp_t;
  exp_t rq[$];
  exp_t qq[$];
  int total = 0;
  int bad = 0;

  logic [7:0] bk [8][32];
  logic [7:0] sh [1024];

  function automatic logic [7:0] m_get(input int id, input int cpu);
    if (id >= NIRQ) return 8'h00;
    if (id < 32) return (cpu < NPE) ? bk[cpu][id] : 8'h00;
    return sh[id];
  endfunction

  function automatic void m_set(input int id, input int cpu, input logic [7:0] v);
    if (id >= NIRQ) return;
    if (id < 32) begin
      if (cpu < NPE) bk[cpu][id] = v & MASK;
    end else sh[id] = v & MASK;
  endfunction

  function automatic int a2word(input logic [11:0] a);
    int n;
    if (a[11:10] != 2'b01) return -1;
    n = int'(a[9:2]);
    if (n == 255 || n >= NW) return -1;
    return n;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: presents a bus request and pushes the expected response.
  task automatic bus_set(input logic wr, input logic [11:0] a, input logic [3:0] s,
                         input logic [31:0] d, input int cpu, input string tag);
    exp_t e;
    int n;
    n = a2word(a);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_strb = s;
    req_wdata = d; req_cpu = 4'(cpu);
    e.tag = tag;
    e.v = '0;
    if (wr) begin
      for (int b = 0; b < 4; b++)
        if (n >= 0 && s[b]) m_set(4 * n + b, cpu, d[8*b +: 8]);
    end else begin
      for (int b = 0; b < 4; b++)
        e.v[8*b +: 8] = (n >= 0) ? m_get(4 * n + b, cpu) : 8'h00;
    end
    rq.push_back(e);
  endtask

  task automatic query_set(input int id, input int cpu, input string tag);
    exp_t e;
    q_valid = 1'b1; q_id = 10'(id); q_cpu = 4'(cpu);
    e.v = {24'h0, m_get(id, cpu)};
    e.tag = tag;
    qq.push_back(e);
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    req_valid = 1'b0; req_write = 1'b0; q_valid = 1'b0;
  endtask

  // Monitor: pops expectations as responses appear.
  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_valid) begin
        if (rq.size() == 0) check("R4 unexpected response", 32'h1, 32'h0);
        else begin
          exp_t e;
          e = rq.pop_front();
          check(e.tag, rsp_rdata, e.v);
        end
      end
      if (q_rvalid) begin
        if (qq.size() == 0) check("R10 unexpected query result", 32'h1, 32'h0);
        else begin
          exp_t e;
          e = qq.pop_front();
          check(e.tag, {24'h0, q_prio}, e.v);
        end
      end
    end
  end

  bit done = 0;
  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < 8; p++) for (int i = 0; i < 32; i++) bk[p][i] = 8'h00;
    for (int i = 0; i < 1024; i++) sh[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 rsp_valid after reset", {31'h0, rsp_valid}, 32'h0);
    check("R1 q_rvalid after reset", {31'h0, q_rvalid}, 32'h0);
    check("R1 q_prio after reset", {24'h0, q_prio}, 32'h0);
    @(posedge clk); #1;

    bus_set(0, 12'h400, 4'hF, 0, 0, "R1 word0 reset"); tick();
    bus_set(0, 12'h430, 4'hF, 0, 2, "R1 word12 reset"); query_set(40, 0, "R1 query reset"); tick();

    bus_set(1, 12'h424, 4'hF, 32'hA1B2C3D4, 0, "R4 write response zero"); tick();
    bus_set(0, 12'h424, 4'hF, 0, 0, "R2 R6 word9 readback"); tick();
    query_set(37, 0, "R2 id37 lane1"); tick();
    query_set(39, 3, "R2 id39 lane3"); tick();

    bus_set(1, 12'h424, 4'b0100, 32'hFFFFFFFF, 0, "R3 lane2 write"); tick();
    bus_set(0, 12'h424, 4'hF, 0, 0, "R3 only lane2 changed"); tick();
    bus_set(1, 12'h424, 4'b0001, 32'h00000017, 1, "R3 lane0 write"); tick();
    bus_set(0, 12'h424, 4'hF, 0, 2, "R3 only lane0 changed"); tick();

    bus_set(1, 12'h408, 4'hF, 32'h11223344, 1, "R8 banked write cpu1"); tick();
    bus_set(0, 12'h408, 4'hF, 0, 1, "R8 cpu1 sees its copy"); tick();
    bus_set(0, 12'h408, 4'hF, 0, 0, "R8 cpu0 copy untouched"); tick();
    query_set(9, 1, "R8 query cpu1 id9"); tick();
    query_set(9, 0, "R8 query cpu0 id9"); tick();

    bus_set(1, 12'h408, 4'hF, 32'hFFFFFFFF, 9, "R9 cpu9 write"); tick();
    bus_set(1, 12'h408, 4'hF, 32'hFFFFFFFF, 5, "R9 cpu5 write"); tick();
    bus_set(0, 12'h408, 4'hF, 0, 9, "R9 cpu9 read zero"); tick();
    bus_set(0, 12'h408, 4'hF, 0, 5, "R9 cpu5 read zero"); tick();
    bus_set(0, 12'h408, 4'hF, 0, 1, "R9 cpu1 copy kept"); tick();
    query_set(9, 9, "R9 query cpu9"); tick();

    bus_set(1, 12'h420, 4'hF, 32'h55667788, 9, "R8 shared write cpu9"); tick();
    bus_set(0, 12'h420, 4'hF, 0, 0, "R8 shared seen by cpu0"); tick();

    bus_set(1, 12'h438, 4'hF, 32'hFFFFFFFF, 0, "R7 word14 write"); tick();
    bus_set(0, 12'h438, 4'hF, 0, 0, "R7 word14 dead lanes"); tick();
    bus_set(1, 12'h43C, 4'hF, 32'hFFFFFFFF, 0, "R7 word15 write"); tick();
    bus_set(0, 12'h43C, 4'hF, 0, 0, "R7 word15 all dead"); tick();
    query_set(57, 0, "R7 id57 live"); tick();
    query_set(58, 0, "R7 id58 dead"); tick();

    bus_set(1, 12'h440, 4'hF, 32'hFFFFFFFF, 0, "R5 word16 write"); tick();
    bus_set(0, 12'h440, 4'hF, 0, 0, "R5 word16 reads zero"); tick();
    bus_set(0, 12'h7FC, 4'hF, 0, 0, "R5 word255 reads zero"); tick();
    bus_set(1, 12'h020, 4'hF, 32'hFFFFFFFF, 0, "R5 outside window write"); tick();
    bus_set(0, 12'h020, 4'hF, 0, 0, "R5 outside window read"); tick();
    bus_set(0, 12'h420, 4'hF, 0, 0, "R5 no alias into word8"); tick();

    query_set(40, 2, "R10 same-cycle query sees old");
    bus_set(1, 12'h428, 4'b0001, 32'h000000C8, 2, "R10 write word10"); tick();
    query_set(40, 2, "R10 next-cycle query sees new"); tick();
    query_set(40, 2, "R10 query repeat"); tick();
    bus_set(0, 12'h428, 4'hF, 0, 3, "R10 bus agrees"); tick();

    repeat (4) @(posedge clk);
    #1;
    check("R4 responses drained", rq.size(), 0);
    check("R10 query results drained", qq.size(), 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule